// File: doc/BRIEF.md
# Differential Biphase Chip Codec for Radio Data Streams

The block turns a serial stream of data bits, at a nominal 1187.5 bit/s, into biphase chips at twice that rate (2375 chips/s). Each data bit is first mark-encoded: a running level flips whenever the bit is 1 and holds when it is 0. Each level is then sent as two chips: the level itself, then its complement. Because of this mark encoding, a receiver that XORs each detected symbol with the one before it gets back the original data bits. Without it, the receiver would only see the XOR of neighbouring bits.

A matching decoder is included in the same top level so the two halves can be checked as a pair. The decoder takes chips one per strobe and groups them in pairs. It uses the first chip of each pair as the symbol, and it emits the XOR of that symbol with the previous one. It raises a flag when the second chip fails to be the complement of the first. Carrier modulation and pulse shaping sit outside this block. The chip-rate enable comes from the surrounding clock-enable logic.

Top module: `rds_biphase_codec`

## Requirements
- R1: After reset, bit_ready is 1 and chip_valid, rx_bit_valid and rx_violation are 0. The mark level and the decoder's previous symbol both start at 0.
- R2: The first chip of each symbol equals the previous mark level XOR the accepted data bit. That chip becomes the new mark level.
- R3: On the next chip_en after a first chip, the encoder emits a second chip that is the complement of the first.
- R4: A bit is taken only on a clock where chip_en, bit_valid and bit_ready are all 1. bit_ready is 0 from that clock until the second chip has been emitted.
- R5: If bit_valid is 0 on a chip_en that would start a symbol, no chip is produced (chip_valid stays 0) and the mark level is left unchanged.
- R6: chip_valid is a one-clock pulse in the cycle after each chip_en that produced a chip. chip_out carries that chip.
- R7: The decoder groups rx_chip_en strobes in pairs. In the cycle after the second strobe of a pair, it pulses rx_bit_valid for one clock, with rx_bit = first chip XOR the previous first chip.
- R8: rx_violation is 1 together with rx_bit_valid when the second chip of the pair equals the first, and 0 otherwise.
- R9: With the chip outputs looped back to the decoder, a run of 16 blocks of 26 bits comes back bit-exact, in order, with no violation flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chip_en | input | 1 | Chip-rate enable for the encoder |
| bit_valid | input | 1 | Data bit offered |
| bit_data | input | 1 | Data bit value |
| bit_ready | output | 1 | Encoder can take a bit on the next symbol-start enable |
| chip_valid | output | 1 | One-clock pulse marking a new chip |
| chip_out | output | 1 | Encoded chip level |
| rx_chip_en | input | 1 | Decoder chip strobe |
| rx_chip | input | 1 | Decoder chip value |
| rx_bit_valid | output | 1 | One-clock pulse marking a decoded bit |
| rx_bit | output | 1 | Decoded data bit |
| rx_violation | output | 1 | Second chip of the pair was not the complement |

## Verification
The hardest case to reach from the ports is a biphase violation. A looped-back encoder can never produce one. The bench therefore hands the decoder inputs over from the encoder to directly driven chip pairs, without resetting. This lets equal-chip pairs land right after a long looped run, with a previous symbol inherited from that run. The encoder side also has bit_valid dropped across symbol-start enables, to show that gaps leave the mark level unchanged.

// File: rtl/rds_bp_pkg.sv
package rds_bp_pkg;

  typedef enum logic {
    PH_FIRST  = 1'b0,
    PH_SECOND = 1'b1
  } bp_phase_t;

  function automatic logic mark_next(input logic level, input logic data);
    return level ^ data;
  endfunction

endpackage

// File: rtl/rds_bp_encoder.sv
module rds_bp_encoder
  import rds_bp_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic chip_en,
  input  logic bit_valid,
  input  logic bit_data,
  output logic bit_ready,
  output logic chip_valid,
  output logic chip_out
);

  bp_phase_t phase_q;
  logic      level_q;
  logic      take;

  assign take      = chip_en && bit_valid && (phase_q == PH_FIRST);
  assign bit_ready = (phase_q == PH_FIRST);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q    <= PH_FIRST;
      level_q    <= 1'b0;
      chip_valid <= 1'b0;
      chip_out   <= 1'b0;
    end else begin
      chip_valid <= 1'b0;
      if (take) begin
        level_q    <= mark_next(level_q, bit_data);
        chip_out   <= mark_next(level_q, bit_data);
        chip_valid <= 1'b1;
        phase_q    <= PH_SECOND;
      end else if (chip_en && phase_q == PH_SECOND) begin
        chip_out   <= ~level_q;
        chip_valid <= 1'b1;
        phase_q    <= PH_FIRST;
      end
    end
  end

endmodule

// File: rtl/rds_bp_decoder.sv
module rds_bp_decoder
  import rds_bp_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic rx_chip_en,
  input  logic rx_chip,
  output logic rx_bit_valid,
  output logic rx_bit,
  output logic rx_violation
);

  bp_phase_t phase_q;
  logic      first_q;
  logic      prev_sym_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q      <= PH_FIRST;
      first_q      <= 1'b0;
      prev_sym_q   <= 1'b0;
      rx_bit_valid <= 1'b0;
      rx_bit       <= 1'b0;
      rx_violation <= 1'b0;
    end else begin
      rx_bit_valid <= 1'b0;
      rx_violation <= 1'b0;
      if (rx_chip_en) begin
        if (phase_q == PH_FIRST) begin
          first_q <= rx_chip;
          phase_q <= PH_SECOND;
        end else begin
          rx_bit       <= first_q ^ prev_sym_q;
          rx_bit_valid <= 1'b1;
          rx_violation <= (rx_chip == first_q);
          prev_sym_q   <= first_q;
          phase_q      <= PH_FIRST;
        end
      end
    end
  end

endmodule

// File: rtl/rds_biphase_codec.sv
module rds_biphase_codec (
  input  logic clk,
  input  logic rst,
  input  logic chip_en,
  input  logic bit_valid,
  input  logic bit_data,
  output logic bit_ready,
  output logic chip_valid,
  output logic chip_out,
  input  logic rx_chip_en,
  input  logic rx_chip,
  output logic rx_bit_valid,
  output logic rx_bit,
  output logic rx_violation
);

  rds_bp_encoder u_enc (
    .clk        (clk),
    .rst        (rst),
    .chip_en    (chip_en),
    .bit_valid  (bit_valid),
    .bit_data   (bit_data),
    .bit_ready  (bit_ready),
    .chip_valid (chip_valid),
    .chip_out   (chip_out)
  );

  rds_bp_decoder u_dec (
    .clk          (clk),
    .rst          (rst),
    .rx_chip_en   (rx_chip_en),
    .rx_chip      (rx_chip),
    .rx_bit_valid (rx_bit_valid),
    .rx_bit       (rx_bit),
    .rx_violation (rx_violation)
  );

endmodule

// File: rtl/rds_bp_checker.sv
module rds_bp_checker (
  input logic clk,
  input logic rst,
  input logic chip_en,
  input logic bit_valid,
  input logic bit_data,
  input logic bit_ready,
  input logic chip_valid,
  input logic chip_out,
  input logic rx_chip_en,
  input logic rx_chip,
  input logic rx_bit_valid,
  input logic rx_bit,
  input logic rx_violation
);

  AST_TAKE_BLOCKS_READY: assert property (@(posedge clk) disable iff (rst)
    (chip_en && bit_valid && bit_ready) |=> (chip_valid && !bit_ready)); // R4

  AST_SECOND_IS_COMPLEMENT: assert property (@(posedge clk) disable iff (rst)
    (chip_en && !bit_ready) |=> (chip_valid && chip_out == !$past(chip_out))); // R3

  AST_READY_RETURNS: assert property (@(posedge clk) disable iff (rst)
    (chip_en && !bit_ready) |=> bit_ready); // R4

  AST_CHIP_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    chip_valid |-> $past(chip_en)); // R6

  AST_IDLE_NO_CHIP: assert property (@(posedge clk) disable iff (rst)
    (chip_en && bit_ready && !bit_valid) |=> (!chip_valid && bit_ready)); // R5

  AST_RX_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rx_bit_valid |=> !rx_bit_valid); // R7

  AST_RX_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
    rx_bit_valid |-> $past(rx_chip_en)); // R7

  AST_VIOL_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
    rx_violation |-> rx_bit_valid); // R8

endmodule

bind rds_biphase_codec rds_bp_checker i_rds_bp_checker (.*);

// File: tb/test_rds_biphase_codec.sv
module test_rds_biphase_codec;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst, chip_en, bit_valid, bit_data;
  logic bit_ready, chip_valid, chip_out;
  logic rx_chip_en, rx_chip, rx_bit_valid, rx_bit, rx_violation;
  logic inj, inj_en, inj_chip;

  assign rx_chip_en = inj ? inj_en   : chip_valid;
  assign rx_chip    = inj ? inj_chip : chip_out;

  rds_biphase_codec i_rds_biphase_codec (
    .clk(clk), .rst(rst), .chip_en(chip_en), .bit_valid(bit_valid),
    .bit_data(bit_data), .bit_ready(bit_ready), .chip_valid(chip_valid),
    .chip_out(chip_out), .rx_chip_en(rx_chip_en), .rx_chip(rx_chip),
    .rx_bit_valid(rx_bit_valid), .rx_bit(rx_bit), .rx_violation(rx_violation)
  );

  int  n_cmp = 0;
  int  n_bad = 0;
  int  cyc   = 0;
  bit  done  = 0;
  bit  tx_q[$];
  bit  sent_q[$];
  int  m_phase = 0;
  int  m_lvl   = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // One clock of the behavioural reference, compared after the edge
  task automatic step();
    bit cen, v, d, exp_stb;
    int exp_chip;
    cen = chip_en; v = bit_valid; d = bit_data;
    exp_stb = 0; exp_chip = 0;
    @(posedge clk); #1;
    if (cen) begin
      if (m_phase == 0) begin
        if (v) begin                       // R2 / R4 acceptance
          m_lvl    = m_lvl ^ int'(d);
          exp_chip = m_lvl;
          exp_stb  = 1;
          m_phase  = 1;
          sent_q.push_back(d);
          void'(tx_q.pop_front());
        end                                // else R5: no chip, level kept
      end else begin                       // R3 complement
        exp_chip = 1 - m_lvl;
        exp_stb  = 1;
        m_phase  = 0;
      end
    end
    chk(chip_valid == exp_stb, "R6 chip_valid", chip_valid, exp_stb);
    if (exp_stb) chk(chip_out == exp_chip[0], "R2/R3 chip_out", chip_out, exp_chip);
    chk(bit_ready == (m_phase == 0), "R4 bit_ready", bit_ready, m_phase == 0);
    if (rx_bit_valid) begin
      if (sent_q.size() == 0) chk(0, "R9 unexpected decoded bit", 1, 0);
      else begin
        bit e;
        e = sent_q.pop_front();
        chk(rx_bit == e, "R9 round-trip bit", rx_bit, e);
      end
    end
    chk(rx_violation == 0, "R9 no violation on loopback", rx_violation, 0);
    cyc++;
    chip_en   = (cyc % 4 == 0);
    bit_valid = (tx_q.size() > 0) && ((cyc / 8) % 7 != 3);
    bit_data  = (tx_q.size() > 0) ? tx_q[0] : 1'b0;
  endtask

  task automatic run_queue();
    while (tx_q.size() > 0 || m_phase != 0) step();
    repeat (8) step();
    chk(sent_q.size() == 0, "R9 all bits decoded", sent_q.size(), 0);
  endtask

  task automatic inj_pair(input bit a, input bit b, input bit exp_bit, input bit exp_v);
    inj_en = 1; inj_chip = a;
    @(posedge clk); #1;
    inj_en = 0;
    chk(rx_bit_valid == 0, "R7 no output after first chip", rx_bit_valid, 0);
    inj_en = 1; inj_chip = b;
    @(posedge clk); #1;
    inj_en = 0;
    chk(rx_bit_valid == 1, "R7 output after second chip", rx_bit_valid, 1);
    chk(rx_bit == exp_bit, "R7 decoded bit", rx_bit, exp_bit);
    chk(rx_violation == exp_v, "R8 violation flag", rx_violation, exp_v);
    @(posedge clk); #1;
    chk(rx_bit_valid == 0, "R7 single pulse", rx_bit_valid, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int s;
    int lvl_before;
    rst = 1; chip_en = 0; bit_valid = 0; bit_data = 0;
    inj = 0; inj_en = 0; inj_chip = 0;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // R1 reset state
    chk(bit_ready == 1, "R1 bit_ready", bit_ready, 1);
    chk(chip_valid == 0, "R1 chip_valid", chip_valid, 0);
    chk(rx_bit_valid == 0, "R1 rx_bit_valid", rx_bit_valid, 0);
    chk(rx_violation == 0, "R1 rx_violation", rx_violation, 0);

    // patterns: all ones, all zeros, alternating (R2, R3, R5 gaps included)
    for (int i = 0; i < 20; i++) tx_q.push_back(1'b1);
    for (int i = 0; i < 20; i++) tx_q.push_back(1'b0);
    for (int i = 0; i < 20; i++) tx_q.push_back(i[0]);
    run_queue();

    // R9: 16 blocks of 26 pseudo-random bits
    s = 32'h1ACE5EED;
    for (int i = 0; i < 16 * 26; i++) begin
      s = s ^ (s << 13); s = s ^ (s >>> 17); s = s ^ (s << 5);
      tx_q.push_back(s[3]);
    end
    run_queue();

    // R5: enables with no data offered produce no chip
    lvl_before = m_lvl;
    repeat (40) step();
    tx_q.push_back(1'b0);
    run_queue();
    chk(m_lvl == lvl_before, "R5 level held over idle", m_lvl, lvl_before);

    // R7 / R8: directly driven pairs; previous symbol inherited from loopback
    inj = 1;
    inj_pair(1'b1, 1'b1, 1'b1 ^ m_lvl[0], 1'b1);  // violation, symbol 1
    inj_pair(1'b0, 1'b1, 1'b1, 1'b0);             // good pair, 0 after 1
    inj_pair(1'b0, 1'b0, 1'b0, 1'b1);             // violation, 0 after 0
    inj_pair(1'b1, 1'b0, 1'b1, 1'b0);             // good pair, 1 after 0

    finish_run();
  end

endmodule